// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is the register and storage half of a small accumulator machine. Six working registers, two character registers and a 4096-word store all exchange data over one 16-bit shared bus. A 3-bit source code picks the single driver of that bus in each cycle. Each register has its own strobes, and every register whose strobe is set in a cycle changes at the next clock edge.

The block has no instruction decoding. An external sequencer drives the source code, the per-register clear, load and increment strobes, and the store's read and write strobes. The block carries out the requested transfers in one clock. The accumulator takes new values from a separate arithmetic-result port and not from the bus. The store is addressed only by the address register.

Top module: `cbus_datapath`

## Requirements
- R1: While the active-low reset is asserted, every register (address, program counter, data, accumulator, instruction, temporary, input character, output character) reads zero.
- R2: The bus carries the source named by `bus_sel`: 0 zero, 1 address register, 2 program counter, 3 data register, 4 accumulator, 5 instruction register, 6 temporary register, 7 store read data.
- R3: The 12-bit address register and program counter are placed on the bus with bits 15..12 forced to zero. When either register loads from the bus, it takes bits 11..0.
- R4: On a register with several strobes, clear wins over load and increment, and the register reads zero after the edge.
- R5: When load and increment are both set without clear, the register takes the bus value and is not incremented.
- R6: Increment adds one modulo the register width: the 12-bit registers wrap from 0xFFF to 0x000, and the 16-bit registers wrap from 0xFFFF to 0x0000.
- R7: On load, the accumulator takes `alu_res`, whatever the bus carries.
- R8: The instruction register takes the whole bus on load. The output character register takes bus bits 7..0 on load. Both have only a load strobe.
- R9: A write stores the bus value at the word addressed by the address register. With `bus_sel`=7 and `mem_rd` high, the stored word appears on the bus in the same cycle. With `bus_sel`=7 and `mem_rd` low, the bus carries zero. Words at other addresses are not changed.
- R10: The input character register captures `inpr_in` only when `inpr_ld` is high.
- R11: A register with no strobe set keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| ar_clr | input | 1 | Address register clear |
| ar_ld | input | 1 | Address register load from bus |
| ar_inr | input | 1 | Address register increment |
| pc_clr | input | 1 | Program counter clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inr | input | 1 | Program counter increment |
| dr_clr | input | 1 | Data register clear |
| dr_ld | input | 1 | Data register load from bus |
| dr_inr | input | 1 | Data register increment |
| ac_clr | input | 1 | Accumulator clear |
| ac_ld | input | 1 | Accumulator load from alu_res |
| ac_inr | input | 1 | Accumulator increment |
| alu_res | input | 16 | Arithmetic result for the accumulator |
| ir_ld | input | 1 | Instruction register load |
| tr_clr | input | 1 | Temporary register clear |
| tr_ld | input | 1 | Temporary register load |
| tr_inr | input | 1 | Temporary register increment |
| outr_ld | input | 1 | Output character load |
| inpr_ld | input | 1 | Input character load |
| inpr_in | input | 8 | Input character data |
| mem_rd | input | 1 | Store read enable |
| mem_wr | input | 1 | Store write enable |
| bus_val | output | 16 | Shared bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| inpr_q | output | 8 | Input character register |
| outr_q | output | 8 | Output character register |

## Verification
The bench loads 0xFFFF through the accumulator into the 12-bit registers. A design that sign-extended them, or kept the wrong slice, would then show 0xFFFF rather than 0x0FFF on the bus, and would not wrap to zero on the next increment. It sets conflicting strobes on one register. A design with the priority reversed would increment where it should load, or load where it should clear. It reads the store with the read strobe low, which must give zero. It checks that a write at one address leaves the word at the neighbouring address intact. It drives the bus with a value different from `alu_res` during an accumulator load. A design that loaded the accumulator from the bus would then hold the wrong word.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int BUS_W = 16;
  localparam int ADR_W = 12;
  localparam int CHR_W = 8;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  // Zero-extend an address-width value to bus width.
  function automatic logic [BUS_W-1:0] widen_addr(input logic [ADR_W-1:0] a);
    return {{(BUS_W-ADR_W){1'b0}}, a};
  endfunction

  // Take the address-width slice of a bus word.
  function automatic logic [ADR_W-1:0] narrow_addr(input logic [BUS_W-1:0] b);
    return b[ADR_W-1:0];
  endfunction

  // Take the character-width slice of a bus word.
  function automatic logic [CHR_W-1:0] narrow_char(input logic [BUS_W-1:0] b);
    return b[CHR_W-1:0];
  endfunction
endpackage

// File: rtl/ctl_reg.sv
module ctl_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  wire do_clr = clr;
  wire do_ld  = ld && !clr;
  wire do_inr = inr && !ld && !clr;
  wire idle   = !clr && !ld && !inr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (do_clr) q <= '0;
    else if (do_ld)  q <= d;
    else if (do_inr) q <= q + ONE;
  end

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> q == '0);
  a_r5_load_over_inc: assert property (@(posedge clk) disable iff (!rst_n)
    do_ld |=> q == $past(d));
  a_r6_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    do_inr |=> q == $past(q) + ONE);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(q));
endmodule

// File: rtl/bus_mux.sv
module bus_mux
  import cbus_pkg::*;
(
  input  logic [2:0]       sel,
  input  logic [ADR_W-1:0] ar,
  input  logic [ADR_W-1:0] pc,
  input  logic [BUS_W-1:0] dr,
  input  logic [BUS_W-1:0] ac,
  input  logic [BUS_W-1:0] ir,
  input  logic [BUS_W-1:0] tr,
  input  logic [BUS_W-1:0] mem,
  input  logic             mem_rd,
  output logic [BUS_W-1:0] bus
);
  bus_src_e src;
  assign src = bus_src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_NONE: bus = '0;
      SRC_AR:   bus = widen_addr(ar);
      SRC_PC:   bus = widen_addr(pc);
      SRC_DR:   bus = dr;
      SRC_AC:   bus = ac;
      SRC_IR:   bus = ir;
      SRC_TR:   bus = tr;
      SRC_MEM:  bus = mem_rd ? mem : '0;
      default:  bus = '0;
    endcase
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
  end

  assign rdata = arr[addr];
endmodule

// File: rtl/cbus_datapath.sv
module cbus_datapath
  import cbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_sel,
  input  logic             ar_clr,
  input  logic             ar_ld,
  input  logic             ar_inr,
  input  logic             pc_clr,
  input  logic             pc_ld,
  input  logic             pc_inr,
  input  logic             dr_clr,
  input  logic             dr_ld,
  input  logic             dr_inr,
  input  logic             ac_clr,
  input  logic             ac_ld,
  input  logic             ac_inr,
  input  logic [15:0]      alu_res,
  input  logic             ir_ld,
  input  logic             tr_clr,
  input  logic             tr_ld,
  input  logic             tr_inr,
  input  logic             outr_ld,
  input  logic             inpr_ld,
  input  logic [7:0]       inpr_in,
  input  logic             mem_rd,
  input  logic             mem_wr,
  output logic [15:0]      bus_val,
  output logic [11:0]      ar_q,
  output logic [11:0]      pc_q,
  output logic [15:0]      dr_q,
  output logic [15:0]      ac_q,
  output logic [15:0]      ir_q,
  output logic [15:0]      tr_q,
  output logic [7:0]       inpr_q,
  output logic [7:0]       outr_q
);
  logic [BUS_W-1:0] mem_rdata;
  wire  [ADR_W-1:0] bus_addr = narrow_addr(bus_val);
  wire  [CHR_W-1:0] bus_char = narrow_char(bus_val);
  wire              ar_quiet = !ar_clr && !ar_ld && !ar_inr;

  bus_mux u_mux (
    .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .mem_rd(mem_rd), .bus(bus_val)
  );

  word_store #(.AW(ADR_W), .DW(BUS_W)) u_store (
    .clk(clk), .we(mem_wr), .addr(ar_q), .wdata(bus_val), .rdata(mem_rdata)
  );

  ctl_reg #(.W(ADR_W)) u_ar (.clk(clk), .rst_n(rst_n), .clr(ar_clr), .ld(ar_ld),
    .inr(ar_inr), .d(bus_addr), .q(ar_q));
  ctl_reg #(.W(ADR_W)) u_pc (.clk(clk), .rst_n(rst_n), .clr(pc_clr), .ld(pc_ld),
    .inr(pc_inr), .d(bus_addr), .q(pc_q));
  ctl_reg #(.W(BUS_W)) u_dr (.clk(clk), .rst_n(rst_n), .clr(dr_clr), .ld(dr_ld),
    .inr(dr_inr), .d(bus_val), .q(dr_q));
  ctl_reg #(.W(BUS_W)) u_ac (.clk(clk), .rst_n(rst_n), .clr(ac_clr), .ld(ac_ld),
    .inr(ac_inr), .d(alu_res), .q(ac_q));
  ctl_reg #(.W(BUS_W)) u_tr (.clk(clk), .rst_n(rst_n), .clr(tr_clr), .ld(tr_ld),
    .inr(tr_inr), .d(bus_val), .q(tr_q));
  ctl_reg #(.W(BUS_W)) u_ir (.clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(ir_ld),
    .inr(1'b0), .d(bus_val), .q(ir_q));
  ctl_reg #(.W(CHR_W)) u_outr (.clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(outr_ld),
    .inr(1'b0), .d(bus_char), .q(outr_q));
  ctl_reg #(.W(CHR_W)) u_inpr (.clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(inpr_ld),
    .inr(1'b0), .d(inpr_in), .q(inpr_q));

  a_r2_dr_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd3 |-> bus_val == dr_q);
  a_r3_ar_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd1 |-> bus_val[15:12] == 4'h0 && bus_val[11:0] == ar_q);
  a_r7_ac_from_alu: assert property (@(posedge clk) disable iff (!rst_n)
    ac_ld && !ac_clr |=> ac_q == $past(alu_res));
  a_r8_outr_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    outr_ld |=> outr_q == $past(bus_val[7:0]));
  a_r9_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && ar_quiet |=> mem_rdata == $past(bus_val));
  a_r9_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd7 && !mem_rd |-> bus_val == 16'h0000);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> ar_q == '0 && pc_q == '0 && ac_q == '0 && outr_q == '0);
endmodule

// File: tb/sim_cbus_datapath.sv
module sim_cbus_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_sel;
  logic ar_clr, ar_ld, ar_inr, pc_clr, pc_ld, pc_inr, dr_clr, dr_ld, dr_inr;
  logic ac_clr, ac_ld, ac_inr, ir_ld, tr_clr, tr_ld, tr_inr, outr_ld, inpr_ld;
  logic mem_rd, mem_wr;
  logic [15:0] alu_res;
  logic [7:0] inpr_in;
  logic [15:0] bus_val, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic [7:0] inpr_q, outr_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  cbus_datapath u0 (.*);

  // {sel, ctl{ar,pc,dr,ac,tr each clr,ld,inr}, alu, exp_bus, ar, pc, dr, ac, tr}
  localparam logic [121:0] VEC [7] = '{
    {3'd0, 15'b000_000_000_010_000, 16'hA5C3, 16'h0000, 12'h000, 12'h000, 16'h0000, 16'hA5C3, 16'h0000},
    {3'd4, 15'b010_000_010_000_000, 16'h0000, 16'hA5C3, 12'h5C3, 12'h000, 16'hA5C3, 16'hA5C3, 16'h0000},
    {3'd3, 15'b000_010_000_000_010, 16'h0000, 16'hA5C3, 12'h5C3, 12'h5C3, 16'hA5C3, 16'hA5C3, 16'hA5C3},
    {3'd2, 15'b000_001_010_000_000, 16'h0000, 16'h05C3, 12'h5C3, 12'h5C4, 16'h05C3, 16'hA5C3, 16'hA5C3},
    {3'd1, 15'b001_000_000_000_011, 16'h0000, 16'h05C3, 12'h5C4, 12'h5C4, 16'h05C3, 16'hA5C3, 16'h05C3},
    {3'd6, 15'b000_000_001_110_000, 16'h0000, 16'h05C3, 12'h5C4, 12'h5C4, 16'h05C4, 16'h0000, 16'h05C3},
    {3'd0, 15'b110_101_000_000_001, 16'h0000, 16'h0000, 12'h000, 12'h000, 16'h05C4, 16'h0000, 16'h05C4}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 3'd0; alu_res = 16'h0; inpr_in = 8'h0;
    {ar_clr, ar_ld, ar_inr, pc_clr, pc_ld, pc_inr, dr_clr, dr_ld, dr_inr} = '0;
    {ac_clr, ac_ld, ac_inr, ir_ld, tr_clr, tr_ld, tr_inr, outr_ld, inpr_ld} = '0;
    {mem_rd, mem_wr} = '0;
  endtask

  // One edge, then settle and release every strobe.
  task automatic cyc();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "ar", {4'h0, ar_q}, 16'h0);
    chk("R1", "pc", {4'h0, pc_q}, 16'h0);
    chk("R1", "dr", dr_q, 16'h0);
    chk("R1", "ac", ac_q, 16'h0);
    chk("R1", "ir", ir_q, 16'h0);
    chk("R1", "tr", tr_q, 16'h0);
    chk("R1", "inpr", {8'h0, inpr_q}, 16'h0);
    chk("R1", "outr", {8'h0, outr_q}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // Table: R2 bus sources, R3 slicing, R4 clear priority, R5 load over increment
    for (int i = 0; i < 7; i++) begin
      logic [121:0] v;
      v = VEC[i];
      bus_sel = v[121:119];
      {ar_clr, ar_ld, ar_inr} = v[118:116];
      {pc_clr, pc_ld, pc_inr} = v[115:113];
      {dr_clr, dr_ld, dr_inr} = v[112:110];
      {ac_clr, ac_ld, ac_inr} = v[109:107];
      {tr_clr, tr_ld, tr_inr} = v[106:104];
      alu_res = v[103:88];
      #1;
      chk("R2", "bus", bus_val, v[87:72]);
      cyc();
      chk("R3", "ar", {4'h0, ar_q}, {4'h0, v[71:60]});
      chk("R3", "pc", {4'h0, pc_q}, {4'h0, v[59:48]});
      chk("R5", "dr", dr_q, v[47:32]);
      chk("R4", "ac", ac_q, v[31:16]);
      chk("R5", "tr", tr_q, v[15:0]);
    end

    // R11: no strobes, all hold
    cyc();
    chk("R11", "dr", dr_q, 16'h05C4);
    chk("R11", "tr", tr_q, 16'h05C4);
    chk("R11", "ar", {4'h0, ar_q}, 16'h0000);

    // R3, R6: wrap of 12-bit and 16-bit registers
    alu_res = 16'hFFFF; ac_ld = 1'b1; cyc();
    bus_sel = 3'd4; ar_ld = 1'b1; pc_ld = 1'b1; #1;
    chk("R2", "bus ac", bus_val, 16'hFFFF);
    cyc();
    bus_sel = 3'd1; #1;
    chk("R3", "bus ar zext", bus_val, 16'h0FFF);
    bus_sel = 3'd2; #1;
    chk("R3", "bus pc zext", bus_val, 16'h0FFF);
    ar_inr = 1'b1; pc_inr = 1'b1; ac_inr = 1'b1; cyc();
    chk("R6", "ar wrap", {4'h0, ar_q}, 16'h0000);
    chk("R6", "pc wrap", {4'h0, pc_q}, 16'h0000);
    chk("R6", "ac wrap", ac_q, 16'h0000);

    // R7: accumulator ignores the bus
    bus_sel = 3'd6; alu_res = 16'h1234; ac_ld = 1'b1; cyc();
    chk("R7", "ac", ac_q, 16'h1234);

    // R8: instruction and output character loads
    bus_sel = 3'd4; ir_ld = 1'b1; outr_ld = 1'b1; cyc();
    chk("R8", "ir", ir_q, 16'h1234);
    chk("R8", "outr", {8'h0, outr_q}, 16'h0034);
    bus_sel = 3'd5; #1;
    chk("R2", "bus ir", bus_val, 16'h1234);

    // R10: input character register
    inpr_in = 8'h7E; inpr_ld = 1'b1; cyc();
    chk("R10", "inpr load", {8'h0, inpr_q}, 16'h007E);
    inpr_in = 8'h11; cyc();
    chk("R10", "inpr hold", {8'h0, inpr_q}, 16'h007E);

    // R9: store write and read
    alu_res = 16'h0ABC; ac_ld = 1'b1; cyc();
    bus_sel = 3'd4; ar_ld = 1'b1; tr_ld = 1'b1; cyc();
    chk("R9", "ar addr", {4'h0, ar_q}, 16'h0ABC);
    alu_res = 16'h5A5A; ac_ld = 1'b1; cyc();
    bus_sel = 3'd4; mem_wr = 1'b1; cyc();
    bus_sel = 3'd7; mem_rd = 1'b1; #1;
    chk("R9", "read", bus_val, 16'h5A5A);
    mem_rd = 1'b0; #1;
    chk("R9", "no rd strobe", bus_val, 16'h0000);
    ar_inr = 1'b1; cyc();
    alu_res = 16'hC3C3; ac_ld = 1'b1; cyc();
    bus_sel = 3'd4; mem_wr = 1'b1; cyc();
    bus_sel = 3'd7; mem_rd = 1'b1; #1;
    chk("R9", "read next", bus_val, 16'hC3C3);
    bus_sel = 3'd6; ar_ld = 1'b1; cyc();
    bus_sel = 3'd7; mem_rd = 1'b1; dr_ld = 1'b1; #1;
    chk("R9", "old word kept", bus_val, 16'h5A5A);
    cyc();
    chk("R9", "dr from store", dr_q, 16'h5A5A);

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "ac after reset", ac_q, 16'h0);
    chk("R1", "ir after reset", ir_q, 16'h0);
    summary();
  end
endmodule